// File: doc/BRIEF.md
# Extended-Precision Classify and Compare Unit

This unit inspects 80-bit extended-precision operands and turns them into four condition bits, C3..C0. An operand has a sign bit in bit 79, a 15-bit biased exponent in bits 78:64 and a 64-bit significand in bits 63:0. The integer bit of the significand is explicit and sits in bit 63. Each operand also comes with an empty flag, which marks a stack slot that holds no value. The unit does not do arithmetic or rounding. It decides what kind of value an operand is, or how two operands are ordered.

There are three modes, chosen by `op_sel`. Examine sorts operand A into one of seven kinds: empty, zero, denormal, unnormal, normal, infinity and NaN. It returns a code for that kind, with the sign in C1. Compare orders A against B. Test orders A against a fixed +0. Compare and test also report an invalid condition and a denormal-operand condition. A helper group copies C0, C2 and C3 onto carry, parity and zero flags so that a host can branch on them directly. The parameter `REG_OUT` chooses between a registered result, one cycle after `in_valid`, and a purely combinational result.

Top module: `xcc_unit`

## Requirements
- R1: With `op_sel` equal to 00, or 11 which behaves the same, the result is an examine code {C3,C2,C1,C0} on `cond_code[3:0]`, with C1 equal to the sign of A. The codes for finite kinds are as follows. A normal value (exponent neither 0 nor all ones, bit 63 set) gives 0,1,s,0. A zero (exponent 0, significand 0) gives 1,0,s,0. A denormal (exponent 0, significand nonzero) gives 1,1,s,0. An unnormal (exponent neither 0 nor all ones, bit 63 clear) gives 0,0,s,0.
- R2: In examine mode, an all-ones exponent whose significand is exactly bit 63 gives infinity, 0,1,s,1. An all-ones exponent with any other significand gives NaN, 0,0,s,1.
- R3: In examine mode an empty A gives 1001 whatever its contents. Examine never produces 1011, 1101 or 1111.
- R4: With `op_sel` 01 (compare), the codes are: A greater than B gives 0000, A less than B gives 0001, and equal gives 1001. C1 is always 0 in compare mode.
- R5: Ordering looks at the sign first, then the exponent, then the significand. When both operands are negative, the magnitude order is reversed.
- R6: +0 and -0 compare equal in both directions.
- R7: If either compared operand is empty or NaN, the code is 1101 and `err_invalid` is 1. Otherwise `err_invalid` is 0 in compare and test modes.
- R8: In compare or test mode, `err_denorm` is 1 exactly when an examined operand is a denormal.
- R9: Examine mode never raises `err_invalid` or `err_denorm`, even for a NaN or an empty operand.
- R10: With `op_sel` 10 (test), A is compared against +0 using the compare codes. `opb` and `opb_empty` have no effect.
- R11: `host_carry` equals C0, `host_parity` equals C2 and `host_zero` equals C3 of the current result.
- R12: With `REG_OUT`=1, `out_valid` and the result appear one clock after `in_valid`. A bubble on the input produces a bubble on the output, and `out_valid` is 0 while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Request is present |
| op_sel | input | 2 | 00/11 examine, 01 compare, 10 test against +0 |
| opa | input | 80 | Operand A (first operand of a compare) |
| opa_empty | input | 1 | Operand A slot is empty |
| opb | input | 80 | Operand B |
| opb_empty | input | 1 | Operand B slot is empty |
| out_valid | output | 1 | Result is valid |
| cond_code | output | 4 | Condition bits C3..C0 |
| err_invalid | output | 1 | Invalid operand (NaN or empty) in compare or test |
| err_denorm | output | 1 | Denormal operand in compare or test |
| host_carry | output | 1 | Copy of C0 |
| host_parity | output | 1 | Copy of C2 |
| host_zero | output | 1 | Copy of C3 |

## Verification
The bench builds the unit with its default parameters: a 15-bit exponent, a 64-bit significand and `REG_OUT`=1. With these settings the exact boundary encodings are reachable. These include the all-ones exponent with only the integer bit set, the pseudo-infinity with a zero significand, and the smallest denormals. The one-cycle result timing is also reachable, so the input bubbles and back-to-back requests in the bench exercise the output valid timing and the reversal of magnitude order for negative operands.

// File: rtl/xcc_pkg.sv
package xcc_pkg;

  typedef enum logic [2:0] {
    K_EMPTY  = 3'd0,
    K_ZERO   = 3'd1,
    K_DENORM = 3'd2,
    K_UNNORM = 3'd3,
    K_NORMAL = 3'd4,
    K_INF    = 3'd5,
    K_NAN    = 3'd6
  } kind_t;

  typedef enum logic [1:0] {
    MODE_EXAM = 2'b00,
    MODE_CMP  = 2'b01,
    MODE_TST  = 2'b10,
    MODE_ALT  = 2'b11
  } mode_t;

  typedef enum logic [1:0] {
    ORD_GT = 2'd0,
    ORD_LT = 2'd1,
    ORD_EQ = 2'd2
  } ord_t;

  localparam logic [3:0] CC_EMPTY = 4'b1001;
  localparam logic [3:0] CC_UNORD = 4'b1101;

  // Examine code: {C3,C2,C1,C0}, with C1 carrying the sign.
  function automatic logic [3:0] exam_code(input kind_t k, input logic s);
    logic [3:0] c;
    case (k)
      K_ZERO:   c = {2'b10, s, 1'b0};
      K_DENORM: c = {2'b11, s, 1'b0};
      K_UNNORM: c = {2'b00, s, 1'b0};
      K_NORMAL: c = {2'b01, s, 1'b0};
      K_INF:    c = {2'b01, s, 1'b1};
      K_NAN:    c = {2'b00, s, 1'b1};
      default:  c = CC_EMPTY;
    endcase
    return c;
  endfunction

  // Signed ordering from effective signs and magnitude relation.
  function automatic ord_t order_of(input logic sa, input logic sb,
                                    input logic mag_gt, input logic mag_eq);
    ord_t o;
    if (sa != sb)       o = sa ? ORD_LT : ORD_GT;
    else if (mag_eq)    o = ORD_EQ;
    else if (mag_gt ^ sa) o = ORD_GT;
    else                o = ORD_LT;
    return o;
  endfunction

  function automatic logic [3:0] cmp_code(input ord_t o);
    logic [3:0] c;
    case (o)
      ORD_GT:  c = 4'b0000;
      ORD_LT:  c = 4'b0001;
      default: c = 4'b1001;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/xcc_classifier.sv
module xcc_classifier
  import xcc_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64
) (
  input  logic [EXP_W+MAN_W:0]   opnd,
  input  logic                   empty,
  output kind_t                  kind,
  output logic                   sign,
  output logic [EXP_W+MAN_W-1:0] key
);
  localparam int KEY_W = EXP_W + MAN_W;
  localparam logic [MAN_W-1:0] INT_ONLY = {1'b1, {(MAN_W-1){1'b0}}};

  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] mn;
  logic exp_top, exp_bot, man_nil, lead_set;

  assign sign     = opnd[KEY_W];
  assign key      = opnd[KEY_W-1:0];
  assign ex       = opnd[KEY_W-1:MAN_W];
  assign mn       = opnd[MAN_W-1:0];
  assign exp_top  = &ex;
  assign exp_bot  = ~|ex;
  assign man_nil  = ~|mn;
  assign lead_set = mn[MAN_W-1];

  always_comb begin
    if (empty)             kind = K_EMPTY;
    else if (exp_top)      kind = (mn == INT_ONLY) ? K_INF : K_NAN;
    else if (exp_bot)      kind = man_nil ? K_ZERO : K_DENORM;
    else if (lead_set)     kind = K_NORMAL;
    else                   kind = K_UNNORM;
  end
endmodule

// File: rtl/xcc_comparator.sv
module xcc_comparator
  import xcc_pkg::*;
#(
  parameter int KEY_W = 79
) (
  input  kind_t            kind_a,
  input  kind_t            kind_b,
  input  logic             sign_a,
  input  logic             sign_b,
  input  logic [KEY_W-1:0] key_a,
  input  logic [KEY_W-1:0] key_b,
  output logic [3:0]       cc,
  output logic             unord,
  output logic             inv,
  output logic             den
);
  logic             zero_a, zero_b;
  logic             es_a, es_b;
  logic [KEY_W-1:0] ek_a, ek_b;
  logic             mag_gt, mag_eq;
  ord_t             ord;

  // Zeros collapse to +0 so that their signs never split them.
  assign zero_a = (kind_a == K_ZERO);
  assign zero_b = (kind_b == K_ZERO);
  assign es_a   = sign_a & ~zero_a;
  assign es_b   = sign_b & ~zero_b;
  assign ek_a   = zero_a ? '0 : key_a;
  assign ek_b   = zero_b ? '0 : key_b;
  assign mag_gt = ek_a > ek_b;
  assign mag_eq = ek_a == ek_b;
  assign ord    = order_of(es_a, es_b, mag_gt, mag_eq);

  assign unord = (kind_a == K_EMPTY) || (kind_a == K_NAN) ||
                 (kind_b == K_EMPTY) || (kind_b == K_NAN);
  assign inv   = unord;
  assign den   = (kind_a == K_DENORM) || (kind_b == K_DENORM);
  assign cc    = unord ? CC_UNORD : cmp_code(ord);
endmodule

// File: rtl/xcc_out_stage.sv
module xcc_out_stage #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       v_in,
  input  logic [3:0] cc_in,
  input  logic       inv_in,
  input  logic       den_in,
  input  logic       cmp_in,
  output logic       v_out,
  output logic [3:0] cc_out,
  output logic       inv_out,
  output logic       den_out,
  output logic       cmp_out
);
  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_out   <= 1'b0;
          cc_out  <= 4'b0000;
          inv_out <= 1'b0;
          den_out <= 1'b0;
          cmp_out <= 1'b0;
        end else begin
          v_out   <= v_in;
          cc_out  <= cc_in;
          inv_out <= inv_in;
          den_out <= den_in;
          cmp_out <= cmp_in;
        end
      end
    end else begin : g_comb
      assign v_out   = v_in;
      assign cc_out  = cc_in;
      assign inv_out = inv_in;
      assign den_out = den_in;
      assign cmp_out = cmp_in;
    end
  endgenerate
endmodule

// File: rtl/xcc_unit.sv
module xcc_unit
  import xcc_pkg::*;
#(
  parameter int EXP_W   = 15,
  parameter int MAN_W   = 64,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [1:0]           op_sel,
  input  logic [EXP_W+MAN_W:0] opa,
  input  logic                 opa_empty,
  input  logic [EXP_W+MAN_W:0] opb,
  input  logic                 opb_empty,
  output logic                 out_valid,
  output logic [3:0]           cond_code,
  output logic                 err_invalid,
  output logic                 err_denorm,
  output logic                 host_carry,
  output logic                 host_parity,
  output logic                 host_zero
);
  localparam int KEY_W = EXP_W + MAN_W;
  localparam int OP_W  = KEY_W + 1;

  mode_t            mode;
  logic             cmp_mode, tst_mode;
  logic [OP_W-1:0]  b_src;
  logic             b_emp;
  kind_t            kind_a, kind_b;
  logic             sign_a, sign_b;
  logic [KEY_W-1:0] key_a, key_b;
  logic [3:0]       exam_cc, cmp_cc, res_cc;
  logic             cmp_unord, cmp_inv, cmp_den;
  logic             res_inv, res_den;
  logic             cmp_q;

  assign mode     = mode_t'(op_sel);
  assign tst_mode = (mode == MODE_TST);
  assign cmp_mode = (mode == MODE_CMP) || tst_mode;

  // Test mode replaces B by a present +0.
  assign b_src = tst_mode ? '0 : opb;
  assign b_emp = tst_mode ? 1'b0 : opb_empty;

  xcc_classifier #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_a (
    .opnd(opa), .empty(opa_empty), .kind(kind_a), .sign(sign_a), .key(key_a)
  );

  xcc_classifier #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_b (
    .opnd(b_src), .empty(b_emp), .kind(kind_b), .sign(sign_b), .key(key_b)
  );

  xcc_comparator #(.KEY_W(KEY_W)) u_cmp (
    .kind_a(kind_a), .kind_b(kind_b), .sign_a(sign_a), .sign_b(sign_b),
    .key_a(key_a), .key_b(key_b), .cc(cmp_cc), .unord(cmp_unord),
    .inv(cmp_inv), .den(cmp_den)
  );

  assign exam_cc = exam_code(kind_a, sign_a);
  assign res_cc  = cmp_mode ? cmp_cc : exam_cc;
  assign res_inv = cmp_mode & cmp_inv;
  assign res_den = cmp_mode & cmp_den;

  xcc_out_stage #(.REG_OUT(REG_OUT)) u_out (
    .clk(clk), .rst_n(rst_n), .v_in(in_valid), .cc_in(res_cc),
    .inv_in(res_inv), .den_in(res_den), .cmp_in(cmp_mode),
    .v_out(out_valid), .cc_out(cond_code), .inv_out(err_invalid),
    .den_out(err_denorm), .cmp_out(cmp_q)
  );

  assign host_carry  = cond_code[0];
  assign host_parity = cond_code[2];
  assign host_zero   = cond_code[3];
endmodule

// File: rtl/xcc_checker.sv
module xcc_checker #(
  parameter bit REG_OUT = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       out_valid,
  input logic [3:0] cc,
  input logic       inv,
  input logic       den,
  input logic       cmp
);
  assert_cmp_code_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cmp |-> (cc == 4'b0000 || cc == 4'b0001 ||
                          cc == 4'b1001 || cc == 4'b1101));

  assert_unord_raises_inv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cmp |-> (cc[2] == inv));

  assert_exam_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !cmp |-> (!inv && !den));

  assert_exam_empty_unique_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !cmp && cc[3] && cc[0] |-> (cc == 4'b1001));

  generate
    if (REG_OUT) begin : g_lat
      assert_one_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));
    end
  endgenerate
endmodule

bind xcc_unit xcc_checker #(.REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .cc(cond_code), .inv(err_invalid), .den(err_denorm), .cmp(cmp_q)
);

// File: tb/tb_xcc_unit.sv
module tb_xcc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op_sel = 2'b00;
  logic [79:0] opa = '0;
  logic        opa_empty = 1'b0;
  logic [79:0] opb = '0;
  logic        opb_empty = 1'b0;
  logic        out_valid;
  logic [3:0]  cond_code;
  logic        err_invalid, err_denorm, host_carry, host_parity, host_zero;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  xcc_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .opa(opa), .opa_empty(opa_empty), .opb(opb), .opb_empty(opb_empty),
    .out_valid(out_valid), .cond_code(cond_code), .err_invalid(err_invalid),
    .err_denorm(err_denorm), .host_carry(host_carry), .host_parity(host_parity),
    .host_zero(host_zero)
  );

  localparam logic [1:0] EXM = 2'b00, CMP = 2'b01, TST = 2'b10, ALT = 2'b11;
  localparam logic [63:0] M_INT = 64'h8000_0000_0000_0000;

  function automatic logic [79:0] fp(input logic s, input logic [14:0] e, input logic [63:0] m);
    return {s, e, m};
  endfunction

  typedef struct {
    logic [3:0] cc;
    logic       inv;
    logic       den;
    string      req;
  } exp_t;
  exp_t sb[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [79:0] a, input logic ae,
                      input logic [79:0] b, input logic be, input logic [3:0] ecc,
                      input logic einv, input logic eden, input string req);
    exp_t e;
    op_sel = op; opa = a; opa_empty = ae; opb = b; opb_empty = be;
    in_valid = 1'b1;
    e.cc = ecc; e.inv = einv; e.den = eden; e.req = req;
    sb.push_back(e);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: pops expected items as results appear.
  always @(negedge clk) begin
    if (rst_n && !done && out_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R12", "unexpected out_valid", 8'd1, 8'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(cond_code == e.cc, e.req, "cond_code", {4'h0, cond_code}, {4'h0, e.cc});
        check({err_invalid, err_denorm} == {e.inv, e.den}, e.req, "inv/den",
              {6'h0, err_invalid, err_denorm}, {6'h0, e.inv, e.den});
        check({host_zero, host_parity, host_carry} == {e.cc[3], e.cc[2], e.cc[0]},
              "R11", "host flags", {5'h0, host_zero, host_parity, host_carry},
              {5'h0, e.cc[3], e.cc[2], e.cc[0]});
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R12 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [79:0] one, two, onep5, pinf, ninf, qnan, pzero, nzero;
    one   = fp(0, 15'h3FFF, M_INT);
    two   = fp(0, 15'h4000, M_INT);
    onep5 = fp(0, 15'h3FFF, 64'hC000_0000_0000_0000);
    pinf  = fp(0, 15'h7FFF, M_INT);
    ninf  = fp(1, 15'h7FFF, M_INT);
    qnan  = fp(0, 15'h7FFF, 64'hC000_0000_0000_0000);
    pzero = fp(0, 15'h0000, 64'h0);
    nzero = fp(1, 15'h0000, 64'h0);

    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R12", "out_valid in reset", {7'h0, out_valid}, 8'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 finite kinds with sign in C1
    send(EXM, one, 0, '0, 0, 4'b0100, 0, 0, "R1");
    send(EXM, one | (80'b1 << 79), 0, '0, 0, 4'b0110, 0, 0, "R1");
    send(EXM, pzero, 0, '0, 0, 4'b1000, 0, 0, "R1");
    send(EXM, nzero, 0, '0, 0, 4'b1010, 0, 0, "R1");
    send(EXM, fp(0, 15'h0, 64'h1), 0, '0, 0, 4'b1100, 0, 0, "R1");
    send(EXM, fp(1, 15'h0, 64'h1), 0, '0, 0, 4'b1110, 0, 0, "R1");
    send(EXM, fp(0, 15'h3FFF, 64'h4000_0000_0000_0000), 0, '0, 0, 4'b0000, 0, 0, "R1");
    send(EXM, fp(1, 15'h3FFF, 64'h4000_0000_0000_0000), 0, '0, 0, 4'b0010, 0, 0, "R1");
    send(ALT, two, 0, '0, 0, 4'b0100, 0, 0, "R1");
    in_valid = 1'b0; @(negedge clk);      // bubble, R12
    // R2 infinities and NaNs; R9 no exceptions in examine
    send(EXM, pinf, 0, '0, 0, 4'b0101, 0, 0, "R2");
    send(EXM, ninf, 0, '0, 0, 4'b0111, 0, 0, "R2");
    send(EXM, qnan, 0, '0, 0, 4'b0001, 0, 0, "R9");
    send(EXM, qnan | (80'b1 << 79), 0, '0, 0, 4'b0011, 0, 0, "R2");
    send(EXM, fp(0, 15'h7FFF, 64'h0), 0, '0, 0, 4'b0001, 0, 0, "R2");
    // R3 empty priority
    send(EXM, one, 1, '0, 0, 4'b1001, 0, 0, "R3");
    send(EXM, qnan | (80'b1 << 79), 1, '0, 0, 4'b1001, 0, 0, "R3");
    // R4 / R5 ordering
    send(CMP, one, 0, two, 0, 4'b0001, 0, 0, "R4");
    send(CMP, two, 0, one, 0, 4'b0000, 0, 0, "R4");
    send(CMP, onep5, 0, onep5, 0, 4'b1001, 0, 0, "R4");
    send(CMP, one | (80'b1 << 79), 0, one, 0, 4'b0001, 0, 0, "R5");
    send(CMP, one | (80'b1 << 79), 0, two | (80'b1 << 79), 0, 4'b0000, 0, 0, "R5");
    send(CMP, one, 0, onep5, 0, 4'b0001, 0, 0, "R5");
    send(CMP, pinf, 0, two, 0, 4'b0000, 0, 0, "R5");
    send(CMP, ninf, 0, two | (80'b1 << 79), 0, 4'b0001, 0, 0, "R5");
    // R6 signed zeros
    send(CMP, pzero, 0, nzero, 0, 4'b1001, 0, 0, "R6");
    send(CMP, nzero, 0, pzero, 0, 4'b1001, 0, 0, "R6");
    // R7 unordered
    send(CMP, qnan, 0, one, 0, 4'b1101, 1, 0, "R7");
    send(CMP, one, 0, one, 1, 4'b1101, 1, 0, "R7");
    send(CMP, one, 1, one, 0, 4'b1101, 1, 0, "R7");
    // R8 denormal operand
    send(CMP, fp(1, 15'h0, 64'h5), 0, pzero, 0, 4'b0001, 0, 1, "R8");
    send(CMP, fp(0, 15'h0, 64'h1), 0, fp(0, 15'h0, 64'h2), 0, 4'b0001, 0, 1, "R8");
    // R10 test against +0, B ignored
    send(TST, two | (80'b1 << 79), 0, qnan, 1, 4'b0001, 0, 0, "R10");
    send(TST, nzero, 0, one, 1, 4'b1001, 0, 0, "R10");
    send(TST, one, 0, qnan, 0, 4'b0000, 0, 0, "R10");
    send(TST, qnan, 0, one, 0, 4'b1101, 1, 0, "R10");
    send(TST, fp(0, 15'h0, 64'h3), 0, ninf, 1, 4'b0000, 0, 1, "R10");

    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R12", "results outstanding", 8'(sb.size()), 8'h0);
    finish_run();
  end
endmodule